// File: doc/BRIEF.md
# Serial Audio Link Frame Controller

This block is the controller end of a serial audio link whose bit clock comes from the codec. It counts that incoming clock to build 256-bit frames. It raises a frame marker for the first 16 bits of every frame, the tag phase, and holds it low for the remaining 240 bits, the data phase. A parallel 256-bit word is shifted out serially, most significant bit first. The first bit is presented on the same rising edge that raises the marker. A 256-bit word is assembled from the serial input, which is sampled on falling edges.

The rest of the system writes the next outgoing word into a holding buffer with a load strobe. That word is moved into the shifter only when a new frame begins. A one-cycle frame-start strobe marks the first bit of each frame. A one-cycle receive-done strobe reports that the assembled receive word is complete. While the power-down input is high the block halts. The marker and the serial output are then held low. On release the block starts a fresh frame at bit zero.

The phase machine has three states. PH_HALT is the halted, outputs-low state. PH_TAG covers bit counts 0 to 15 with the marker high. PH_DATA covers bit counts 16 to 255 with the marker low. Its transitions are as follows:
- halt-to-tag: in PH_HALT with power-down low.
- tag-to-data: in PH_TAG at count 15.
- data-to-tag: in PH_DATA at count 255, which starts the next frame.
- any-to-halt: in PH_TAG or PH_DATA with power-down high.

Every transition into PH_TAG clears the count and loads the outgoing shifter.

Top module: `serial_link_ctl`

## Requirements
- R1: While rst_n is low, fr_mark, ser_out, fr_start and rx_done are 0 and rx_word is all zeros. The holding buffer clears to zero.
- R2: Each frame lasts exactly 256 bit-clock cycles, and fr_mark is 1 for the first 16 of them and 0 for the other 240.
- R3: fr_mark and ser_out change only on the rising edge of bit_clk.
- R4: The word in the shifter is sent on ser_out with bit 255 first. Bit 255 is present in the same cycle in which fr_mark first goes high and fr_start is 1. Bit 255-k is present in cycle k of the frame.
- R5: ser_in is sampled on the falling edge of bit_clk. The bit sampled in frame cycle k becomes bit 255-k of rx_word.
- R6: rx_done is 1 for exactly one bit-clock period, starting at the falling edge on which the 256th bit of a frame is sampled. From that edge rx_word holds the completed frame.
- R7: When pwr_down is 1 at a rising edge, fr_mark, ser_out, fr_start and rx_done are 0 from that edge until the block leaves the halted state. No receive-done strobe is produced for a frame cut short.
- R8: After pwr_down returns to 0, the next rising edge starts a new frame at count zero. fr_start and fr_mark are then 1, and ser_out carries bit 255 of the holding buffer.
- R9: A tx_load pulse during a frame stores tx_word in the holding buffer without altering the bits being sent. The stored word is sent in the next frame that starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock supplied by the codec |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Link power-down; halts the block and forces outputs low |
| tx_word | input | 256 | Next outgoing frame |
| tx_load | input | 1 | Store tx_word into the holding buffer at this rising edge |
| ser_in | input | 1 | Serial data from the codec |
| fr_mark | output | 1 | Frame marker, high during the tag phase |
| ser_out | output | 1 | Serial data to the codec |
| fr_start | output | 1 | High in the first cycle of each frame |
| rx_word | output | 256 | Last completely received frame |
| rx_done | output | 1 | One-period strobe when rx_word is updated |

## Verification
A wrong bit count or phase state shows up on fr_mark at its next expected change. That is at most 16 cycles into a tag phase, or 240 cycles into a data phase. It also shows as a frame-start strobe that arrives off the 256-cycle rhythm. A shifter loaded at the wrong moment, or a buffer that is not held back, puts a wrong first bit on ser_out in the first cycle of a frame. The receive side is observed once per frame, when rx_done rises. At that point a one-edge skew in sampling appears as a word shifted by one bit.

// File: rtl/frame_link_pkg.sv
package frame_link_pkg;

    // Phase of the link frame
    typedef enum logic [1:0] {
        PH_HALT = 2'd0,
        PH_TAG  = 2'd1,
        PH_DATA = 2'd2
    } phase_t;

    localparam int unsigned DEF_FRAME_BITS = 256;
    localparam int unsigned DEF_TAG_BITS   = 16;

endpackage

// File: rtl/link_phase_fsm.sv
module link_phase_fsm
    import frame_link_pkg::*;
#(
    parameter int unsigned FRAME_BITS = DEF_FRAME_BITS,
    parameter int unsigned TAG_BITS   = DEF_TAG_BITS,
    localparam int unsigned CNT_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_req,
    output logic             enter_frame,
    output logic             running,
    output logic             in_tag,
    output logic             first_bit,
    output logic             last_bit,
    output logic [CNT_W-1:0] bit_idx
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] TAG_END  = CNT_W'(TAG_BITS - 1);

    phase_t           state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_HALT;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx    = state;
        cnt_nx      = cnt + 1'b1;
        enter_frame = 1'b0;
        unique case (state)
            PH_HALT: begin
                cnt_nx = '0;
                if (!halt_req) begin
                    state_nx    = PH_TAG;
                    enter_frame = 1'b1;
                end
            end
            PH_TAG: begin
                if (halt_req) begin
                    state_nx = PH_HALT;
                    cnt_nx   = '0;
                end else if (cnt == TAG_END) begin
                    state_nx = PH_DATA;
                end
            end
            PH_DATA: begin
                if (halt_req) begin
                    state_nx = PH_HALT;
                    cnt_nx   = '0;
                end else if (cnt == LAST_IDX) begin
                    state_nx    = PH_TAG;
                    cnt_nx      = '0;
                    enter_frame = 1'b1;
                end
            end
            default: begin
                state_nx = PH_HALT;
                cnt_nx   = '0;
            end
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        running   = (state != PH_HALT);
        in_tag    = (state == PH_TAG);
        first_bit = (state == PH_TAG) && (cnt == '0);
        last_bit  = (state == PH_DATA) && (cnt == LAST_IDX);
        bit_idx   = cnt;
    end

endmodule

// File: rtl/link_tx_shifter.sv
module link_tx_shifter #(
    parameter int unsigned FRAME_BITS = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] word,
    input  logic                  enter_frame,
    input  logic                  running,
    output logic                  ser_bit
);

    logic [FRAME_BITS-1:0] hold_q;
    logic [FRAME_BITS-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            shift_q <= '0;
        end else begin
            if (load)
                hold_q <= word;
            if (enter_frame)
                shift_q <= hold_q;
            else if (running)
                shift_q <= {shift_q[FRAME_BITS-2:0], 1'b0};
        end
    end

    assign ser_bit = running & shift_q[FRAME_BITS-1];

endmodule

// File: rtl/link_rx_shifter.sv
module link_rx_shifter #(
    parameter int unsigned FRAME_BITS = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  running,
    input  logic                  last_bit,
    input  logic                  ser_bit,
    output logic [FRAME_BITS-1:0] word,
    output logic                  done
);

    logic [FRAME_BITS-1:0] shift_q;
    logic [FRAME_BITS-1:0] shift_nx;

    assign shift_nx = {shift_q[FRAME_BITS-2:0], ser_bit};

    // Falling-edge capture
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            word    <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (running) begin
                shift_q <= shift_nx;
                if (last_bit) begin
                    word <= shift_nx;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/serial_link_ctl.sv
module serial_link_ctl
    import frame_link_pkg::*;
#(
    parameter int unsigned FRAME_BITS = DEF_FRAME_BITS,
    parameter int unsigned TAG_BITS   = DEF_TAG_BITS
) (
    input  logic                  bit_clk,
    input  logic                  rst_n,
    input  logic                  pwr_down,
    input  logic [FRAME_BITS-1:0] tx_word,
    input  logic                  tx_load,
    input  logic                  ser_in,
    output logic                  fr_mark,
    output logic                  ser_out,
    output logic                  fr_start,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  rx_done
);

    localparam int unsigned CNT_W = $clog2(FRAME_BITS);

    logic             enter_frame;
    logic             running;
    logic             in_tag;
    logic             first_bit;
    logic             last_bit;
    logic [CNT_W-1:0] bit_idx;

    link_phase_fsm #(
        .FRAME_BITS (FRAME_BITS),
        .TAG_BITS   (TAG_BITS)
    ) u_fsm (
        .clk         (bit_clk),
        .rst_n       (rst_n),
        .halt_req    (pwr_down),
        .enter_frame (enter_frame),
        .running     (running),
        .in_tag      (in_tag),
        .first_bit   (first_bit),
        .last_bit    (last_bit),
        .bit_idx     (bit_idx)
    );

    link_tx_shifter #(
        .FRAME_BITS (FRAME_BITS)
    ) u_tx (
        .clk         (bit_clk),
        .rst_n       (rst_n),
        .load        (tx_load),
        .word        (tx_word),
        .enter_frame (enter_frame),
        .running     (running),
        .ser_bit     (ser_out)
    );

    link_rx_shifter #(
        .FRAME_BITS (FRAME_BITS)
    ) u_rx (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .running  (running),
        .last_bit (last_bit),
        .ser_bit  (ser_in),
        .word     (rx_word),
        .done     (rx_done)
    );

    assign fr_mark  = in_tag;
    assign fr_start = first_bit;

    logic unused_idx;
    assign unused_idx = ^bit_idx;

endmodule

// File: rtl/link_ctl_chk.sv
module link_ctl_chk #(
    parameter int unsigned TAG_BITS = 16
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_down,
    input logic fr_mark,
    input logic ser_out,
    input logic fr_start,
    input logic rx_done
);

    logic [7:0] high_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            high_run <= '0;
        else if (fr_mark)
            high_run <= high_run + 8'd1;
        else
            high_run <= '0;
    end

    // R2
    tag_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fr_mark) && !$past(pwr_down)) |-> (high_run == 8'(TAG_BITS)));

    // R4
    start_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fr_start |-> $rose(fr_mark));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R7
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_down) |-> (!fr_mark && !ser_out && !fr_start && !rx_done));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_down) && !pwr_down) |=> fr_start);

endmodule

bind serial_link_ctl link_ctl_chk #(
    .TAG_BITS (TAG_BITS)
) u_link_ctl_chk (
    .clk      (bit_clk),
    .rst_n    (rst_n),
    .pwr_down (pwr_down),
    .fr_mark  (fr_mark),
    .ser_out  (ser_out),
    .fr_start (fr_start),
    .rx_done  (rx_done)
);

// File: tb/serial_link_ctl_bench.sv
module serial_link_ctl_bench;

    localparam int W = 256;
    localparam logic [W-1:0] MARK_EXP = {{16{1'b1}}, {240{1'b0}}};
    localparam logic [W-1:0] WA = {16{16'hC3A5}};
    localparam logic [W-1:0] WB = {64{4'h6}};
    localparam logic [W-1:0] WC = {32{8'h9E}};
    localparam logic [W-1:0] P1 = {8{32'h1234_5678}};
    localparam logic [W-1:0] P2 = {8{32'hF0E1_D2C3}};
    localparam logic [W-1:0] P3 = {16{16'h8001}};
    localparam logic [W-1:0] P4 = {8{32'h5A5A_0FF1}};

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pwr_down;
    logic [W-1:0]  tx_word;
    logic          tx_load;
    logic          ser_in;
    logic          fr_mark;
    logic          ser_out;
    logic          fr_start;
    logic [W-1:0]  rx_word;
    logic          rx_done;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    serial_link_ctl u_serial_link_ctl (
        .bit_clk  (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .tx_word  (tx_word),
        .tx_load  (tx_load),
        .ser_in   (ser_in),
        .fr_mark  (fr_mark),
        .ser_out  (ser_out),
        .fr_start (fr_start),
        .rx_word  (rx_word),
        .rx_done  (rx_done)
    );

    task automatic check(input bit ok, input string req,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #2;
    endtask

    task automatic wait_start;
        for (int i = 0; i < 600; i++) begin
            if (fr_start === 1'b1) break;
            step();
        end
        check(fr_start === 1'b1, "R8 frame start seen", W'(fr_start), W'(1));
    endtask

    // Runs one frame starting at cycle 0; ends at cycle 0 of the next frame.
    task automatic run_frame(input logic [W-1:0] tx_exp, input logic [W-1:0] rx_pat,
                             input bit do_load, input int load_at,
                             input logic [W-1:0] load_val, input string tag);
        logic [W-1:0] mark_v = '0;
        logic [W-1:0] out_v  = '0;
        logic         done_early = 1'b0;
        for (int k = 0; k < W; k++) begin
            mark_v[W-1-k] = fr_mark;
            out_v[W-1-k]  = ser_out;
            ser_in        = rx_pat[W-1-k];
            if (k == 1 || k == W-1)
                done_early = done_early | rx_done;
            if (do_load && k == load_at) begin
                tx_word = load_val;
                tx_load = 1'b1;
            end
            if (do_load && k == load_at + 1)
                tx_load = 1'b0;
            step();
        end
        // R2 R3 marker pattern sampled once per cycle between rising edges
        check(mark_v === MARK_EXP, {"R2 R3 marker ", tag}, mark_v, MARK_EXP);
        // R4 R9 serial output word
        check(out_v === tx_exp, {"R4 R9 serial out ", tag}, out_v, tx_exp);
        check(done_early === 1'b0, {"R6 done timing ", tag}, W'(done_early), W'(0));
        check(rx_done === 1'b1, {"R6 done strobe ", tag}, W'(rx_done), W'(1));
        // R5 falling-edge capture gives the exact pattern
        check(rx_word === rx_pat, {"R5 R6 receive word ", tag}, rx_word, rx_pat);
        check(fr_start === 1'b1, {"R2 next frame start ", tag}, W'(fr_start), W'(1));
    endtask

    task automatic t_reset;
        rst_n = 1'b0; pwr_down = 1'b0; tx_load = 1'b0; tx_word = '0; ser_in = 1'b1;
        repeat (3) step();
        check({fr_mark, ser_out, fr_start, rx_done} === 4'b0, "R1 outputs in reset",
              W'({fr_mark, ser_out, fr_start, rx_done}), W'(0));
        check(rx_word === '0, "R1 rx word in reset", rx_word, '0);
        rst_n = 1'b1;
        step();
        wait_start();
    endtask

    task automatic t_frames;
        run_frame('0, P1, 1'b1, 100, WA, "f1");
        run_frame(WA, P2, 1'b1, 200, WB, "f2");
        run_frame(WB, P3, 1'b0, 0, '0, "f3");
    endtask

    task automatic t_power_down;
        logic any_high = 1'b0;
        logic done_seen = 1'b0;
        for (int k = 0; k < 50; k++) begin
            ser_in = k[0];
            step();
        end
        pwr_down = 1'b1;
        ser_in   = 1'b1;
        step();
        for (int k = 0; k < 20; k++) begin
            any_high = any_high | fr_mark | ser_out | fr_start;
            done_seen = done_seen | rx_done;
            if (k == 5) begin
                tx_word = WC;
                tx_load = 1'b1;
            end
            if (k == 6)
                tx_load = 1'b0;
            step();
        end
        check(any_high === 1'b0, "R7 outputs low in halt", W'(any_high), W'(0));
        check(done_seen === 1'b0, "R7 no done for cut frame", W'(done_seen), W'(0));
        pwr_down = 1'b0;
        step();
        check({fr_start, fr_mark, ser_out} === 3'b111, "R8 fresh frame on release",
              W'({fr_start, fr_mark, ser_out}), W'(3'b111));
        run_frame(WC, P4, 1'b0, 0, '0, "after release");
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_frames();
        t_power_down();
        finish_run();
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

endmodule